// File: doc/BRIEF.md
# Asynchronous Parallel Host Bus Slave

This block is the display-controller end of a strobe-driven parallel host bus of the 8080 style. The host presents a byte together with a chip-select, a read strobe, a write strobe and a data/command select, all low-active except the select. The block brings every pin into the system clock domain through a two-stage synchronizer. It then finds the rising edges of the two strobes and turns each qualified write into a one-cycle pulse. A pulse goes either to the command logic or to the display-memory write logic, together with the captured byte.

Reads go through a prefetch stage. A read pointer is loaded by the surrounding command logic whenever a new column address is set, and that load also clears the prefetch register. While a read strobe is low, the block presents the byte already held in the prefetch register. When the strobe rises, the block issues one memory fetch at the pointer and advances the pointer. The first read after a pointer load therefore returns a dummy byte, and each later read returns the byte fetched by the read before it.

The data bus is split into an input, an output and an output enable, for a pad cell outside the block. The output enable follows the raw chip-select and read strobe pins without going through any register.

Top module: `hbus_par_slave`

## Requirements
- R1: After reset, cmd_vld, wd_vld and mem_req are low, bus_dout is 0x00, and with the bus idle (all strobes and chip-select high) bus_doe is low.
- R2: A rising edge of bus_wr_n while bus_cs_n is low and bus_dc is low produces cmd_vld high for exactly one cycle, with cmd_byte equal to the byte on bus_din. The pulse starts at the third rising clock edge after the pin edge.
- R3: The same write with bus_dc high produces wd_vld for exactly one cycle with wd_byte equal to bus_din, at the same latency as R2. cmd_vld and wd_vld are never high together.
- R4: Strobe edges that occur while bus_cs_n is high have no effect. A write produces no pulse. A read issues no fetch, leaves the read pointer unchanged and leaves the prefetched byte unchanged.
- R5: bus_doe is high exactly while both bus_cs_n and bus_rd_n are low. This follows the pins combinationally.
- R6: A rising edge of bus_rd_n while bus_cs_n is low raises mem_req for exactly one cycle, at the third rising clock edge after the pin edge, with mem_addr equal to the read pointer. The pointer then advances by one.
- R7: A ptr_load pulse sets the read pointer to ptr_value and clears the prefetch register to 0x00, so the next read presents 0x00 as its dummy byte. Memory returns mem_rdata in the cycle after mem_req. Every later read presents the byte fetched by the read before it.
- R8: The read pointer wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_dc | input | 1 | High: display data, low: command |
| bus_din | input | DATA_W | Data bus from host |
| bus_dout | output | DATA_W | Data bus to host (prefetched byte) |
| bus_doe | output | 1 | Output enable for the data pad |
| cmd_vld | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | DATA_W | Command byte |
| wd_vld | output | 1 | One-cycle display data strobe |
| wd_byte | output | DATA_W | Display data byte |
| ptr_load | input | 1 | Load read pointer, clear prefetch |
| ptr_value | input | ADDR_W | Value for the read pointer |
| mem_req | output | 1 | One-cycle memory fetch request |
| mem_addr | output | ADDR_W | Fetch address |
| mem_rdata | input | DATA_W | Fetched byte, valid the cycle after mem_req |

## Verification
The assertions take for granted that each strobe phase lasts several clock cycles. They also assume that chip-select, the data/command select and the data byte are held steady around the strobe rise until the synchronized edge has been seen, that reads and writes never overlap, and that ptr_load is never pulsed while a fetch is in flight. The stimulus holds every strobe phase for at least two cycles. It keeps chip-select and the data lines steady for four cycles after a strobe rises, spaces reads far enough apart that each fetch is finished before the next read, and pulses ptr_load only when the bus is idle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_CMD  = 2'd1,
        WK_DATA = 2'd2
    } wr_kind_e;

    localparam int CTRL_W = 4;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/hbus_edge.sv
module hbus_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/hbus_rdpipe.sv
module hbus_rdpipe #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rd_byte
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic [DATA_W-1:0] buffer;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.pend = st_q.req;
        if (st_q.pend) begin
            st_d.buffer = mem_rdata;
        end
        if (ptr_load) begin
            st_d.ptr    = ptr_value;
            st_d.buffer = '0;
            st_d.pend   = 1'b0;
        end else if (rd_go) begin
            st_d.req  = 1'b1;
            st_d.addr = st_q.ptr;
            st_d.ptr  = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req  = st_q.req;
    assign mem_addr = st_q.addr;
    assign rd_byte  = st_q.buffer;
endmodule

// File: rtl/hbus_par_slave.sv
module hbus_par_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_dc,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              cmd_vld,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              wd_vld,
    output logic [DATA_W-1:0] wd_byte,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int SYNC_W = CTRL_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b0111, {DATA_W{1'b0}}};

    logic [SYNC_W-1:0] sync_lvl;
    logic              dc_s, cs_n_s, rd_n_s, wr_n_s;
    logic [DATA_W-1:0] din_s;
    logic [1:0]        rise;
    logic              rd_go;

    hbus_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_dc, bus_cs_n, bus_rd_n, bus_wr_n, bus_din}),
        .sync_o  (sync_lvl)
    );

    assign {dc_s, cs_n_s, rd_n_s, wr_n_s, din_s} = sync_lvl;

    hbus_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({rd_n_s, wr_n_s}),
        .rise_o (rise)
    );

    typedef struct packed {
        logic              cmd_vld;
        logic [DATA_W-1:0] cmd_byte;
        logic              wd_vld;
        logic [DATA_W-1:0] wd_byte;
    } wst_t;

    wst_t     w_d, w_q;
    wr_kind_e kind;

    always_comb begin
        w_d        = w_q;
        w_d.cmd_vld = 1'b0;
        w_d.wd_vld  = 1'b0;
        kind        = WK_NONE;
        if (rise[0] && !cs_n_s) begin
            kind = dc_s ? WK_DATA : WK_CMD;
        end
        case (kind)
            WK_CMD: begin
                w_d.cmd_vld  = 1'b1;
                w_d.cmd_byte = din_s;
            end
            WK_DATA: begin
                w_d.wd_vld  = 1'b1;
                w_d.wd_byte = din_s;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_go = rise[1] && !cs_n_s;

    hbus_rdpipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .rd_byte   (bus_dout)
    );

    assign bus_doe  = !bus_cs_n && !bus_rd_n;
    assign cmd_vld  = w_q.cmd_vld;
    assign cmd_byte = w_q.cmd_byte;
    assign wd_vld   = w_q.wd_vld;
    assign wd_byte  = w_q.wd_byte;
endmodule

// File: rtl/hbus_par_slave_chk.sv
module hbus_par_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_doe,
    input logic              cmd_vld,
    input logic              wd_vld,
    input logic              mem_req,
    input logic              ptr_load,
    input logic [DATA_W-1:0] bus_dout
);
    assert_cmd_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> !cmd_vld);

    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld && wd_vld));

    assert_no_drive_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_doe);

    assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_dummy_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (bus_dout == '0) && !mem_req);
endmodule

bind hbus_par_slave hbus_par_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_doe  (bus_doe),
    .cmd_vld  (cmd_vld),
    .wd_vld   (wd_vld),
    .mem_req  (mem_req),
    .ptr_load (ptr_load),
    .bus_dout (bus_dout)
);

// File: tb/hbus_par_slave_tb.sv
`timescale 1ns/1ps
module hbus_par_slave_tb;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_dc = 1'b0;
    logic [DW-1:0] bus_din = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic          cmd_vld, wd_vld, mem_req;
    logic [DW-1:0] cmd_byte, wd_byte;
    logic          ptr_load = 1'b0;
    logic [AW-1:0] ptr_value = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    logic [DW-1:0] e_cmd [int];
    logic [DW-1:0] e_wd  [int];
    int            e_req [int];
    int            m_ptr = 0;
    logic [DW-1:0] m_buf = '0;

    always #2.5 clk = ~clk;

    hbus_par_slave #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dc(bus_dc),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .wd_vld(wd_vld), .wd_byte(wd_byte),
        .ptr_load(ptr_load), .ptr_value(ptr_value),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] mem_f(input int a);
        int v;
        v = a * 37 + 11;
        return v[DW-1:0];
    endfunction

    // memory model: data valid the cycle after the request
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) mem_rdata <= mem_f(int'(mem_addr));
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (live) begin
            check("R2 cmd_vld", int'(cmd_vld), e_cmd.exists(cyc) ? 1 : 0);
            if (e_cmd.exists(cyc)) check("R2 cmd_byte", int'(cmd_byte), int'(e_cmd[cyc]));
            check("R3 wd_vld", int'(wd_vld), e_wd.exists(cyc) ? 1 : 0);
            if (e_wd.exists(cyc)) check("R3 wd_byte", int'(wd_byte), int'(e_wd[cyc]));
            check("R6 mem_req", int'(mem_req), e_req.exists(cyc) ? 1 : 0);
            if (e_req.exists(cyc)) check("R6 R8 mem_addr", int'(mem_addr), e_req[cyc]);
            check("R5 bus_doe", int'(bus_doe), (!bus_cs_n && !bus_rd_n) ? 1 : 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input bit sel, input bit dc, input logic [DW-1:0] val);
        bus_cs_n = !sel;
        bus_dc   = dc;
        bus_din  = val;
        tick(1);
        bus_wr_n = 1'b0;
        tick(2);
        bus_wr_n = 1'b1;
        if (sel) begin
            if (dc) e_wd[cyc + 3] = val;
            else    e_cmd[cyc + 3] = val;
        end
        tick(4);
        bus_cs_n = 1'b1;
        tick(2);
    endtask

    task automatic host_read(input bit sel, input string tag);
        bus_cs_n = !sel;
        tick(1);
        bus_rd_n = 1'b0;
        tick(3);
        if (sel) check(tag, int'(bus_dout), int'(m_buf));
        bus_rd_n = 1'b1;
        if (sel) begin
            e_req[cyc + 3] = m_ptr;
            m_buf = mem_f(m_ptr);
            m_ptr = (m_ptr + 1) & AMASK;
        end
        tick(4);
        bus_cs_n = 1'b1;
        tick(6);
    endtask

    task automatic load_ptr(input int v);
        ptr_value = v[AW-1:0];
        ptr_load  = 1'b1;
        tick(1);
        ptr_load  = 1'b0;
        m_ptr = v & AMASK;
        m_buf = '0;
        tick(2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 cmd_vld", int'(cmd_vld), 0);
        check("R1 wd_vld", int'(wd_vld), 0);
        check("R1 mem_req", int'(mem_req), 0);
        check("R1 bus_dout", int'(bus_dout), 0);
        check("R1 bus_doe", int'(bus_doe), 0);
        live = 1'b1;
        tick(2);

        // R2 / R3 writes of both kinds
        host_write(1'b1, 1'b0, 8'hAE);
        host_write(1'b1, 1'b1, 8'h55);
        host_write(1'b1, 1'b0, 8'h21);
        host_write(1'b1, 1'b1, 8'hFF);
        host_write(1'b1, 1'b1, 8'h00);
        // R4 deselected write: no strobe expected
        host_write(1'b0, 1'b1, 8'h12);
        host_write(1'b0, 1'b0, 8'h34);

        // R1 read with no load yet presents the reset byte
        host_read(1'b1, "R1 first read after reset");

        // R7 dummy read then prefetched data
        load_ptr(5);
        host_read(1'b1, "R7 dummy byte");
        host_read(1'b1, "R7 prefetched byte");
        host_read(1'b1, "R7 prefetched byte");
        // R4 deselected read leaves pointer and prefetch alone
        host_read(1'b0, "R4");
        host_read(1'b1, "R4 byte after ignored read");
        // write between reads does not disturb the read path
        host_write(1'b1, 1'b1, 8'hA5);
        host_read(1'b1, "R7 byte after interleaved write");

        // R8 wrap of the pointer
        load_ptr(AMASK);
        host_read(1'b1, "R8 dummy at top address");
        host_read(1'b1, "R8 byte at top address");
        host_read(1'b1, "R8 byte after wrap");
        host_read(1'b1, "R8 second byte after wrap");

        // reload in the middle of a stream restarts with a dummy
        load_ptr(300);
        host_read(1'b1, "R7 dummy after reload");
        host_read(1'b1, "R7 byte after reload");

        tick(10);
        live = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule